// File: doc/BRIEF.md
# Clock and alarm setting controller

This block keeps a 24-hour time of day in BCD with one-second resolution and holds a separate alarm time. A free-running divider turns the fast system clock into a once-per-second tick (a 1024 Hz clock with a 10-bit divider by default). Three key inputs carry one-cycle pulses from debounced buttons: a set key, a step key and a view key.

One mode sequencer serves both the running clock and the alarm register. From the clock display, set opens hour adjust and each step press moves on: to minute adjust, then to a step that clears the seconds, then back to the display. From the alarm display the same presses walk through alarm hours, minutes and seconds. The view key flips between the two displays. A field under adjustment advances once per tick for as long as its step is active. Fields that are not being adjusted keep counting.

The outputs carry the selected view's digits, the alarm time, one flag for each field under adjustment, a view indicator and an alarm-match flag. Debouncing the keys and driving the display segments are left to neighbouring logic.

Top module: `clock_alarm_ctrl`

## Requirements
- R1: Time is held as BCD pairs (high nibble = tens). Seconds and minutes wrap 59 to 00, with a seconds wrap advancing minutes and a minutes wrap advancing hours in normal running. Hours wrap 23 to 00.
- R2: After reset is released, the time advances once every 2^DIV_BITS clock edges. The first advance happens on the 2^DIV_BITS-th rising edge.
- R3: In clock display, set enters hour adjust. Each step press then moves hour adjust to minute adjust, minute adjust to seconds-clear, and seconds-clear back to display. Set is ignored outside the two display states, and step is ignored inside them. The flags blink_hr, blink_min and blink_sec are high in the hour, minute and seconds steps respectively, and all are low in the display states.
- R4: In hour adjust, hours advance by one on every tick and wrap 23 to 00. In minute adjust, minutes advance by one on every tick and wrap 59 to 00.
- R5: While in seconds-clear, seconds read 00 from the next edge onward, and minutes and hours hold still.
- R6: In alarm display, set enters alarm-hour setting, and step walks through alarm minutes, then alarm seconds, then back to alarm display. The selected alarm field advances once per tick. The running clock is unaffected, and the show_* outputs present the alarm time while view_alm is high.
- R7: The view key toggles between clock display and alarm display only from those two states. It wins over set when both arrive together, and it is ignored in every adjust or setting step.
- R8: While a field is being adjusted, no carry passes into or out of it. Hours stay fixed in minute adjust, a minutes wrap there leaves hours unchanged, and a seconds wrap there leaves minutes unchanged.
- R9: Seconds keep counting during hour adjust and minute adjust.
- R10: Synchronous active-high reset selects clock display and clears the time, the alarm and the divider to zero.
- R11: alarm_hit is high exactly when the running time equals the alarm time and no alarm setting step is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_set | input | 1 | Set key pulse |
| key_step | input | 1 | Step key pulse |
| key_view | input | 1 | View toggle key pulse |
| show_hr | output | 8 | BCD hours of the selected view |
| show_min | output | 8 | BCD minutes of the selected view |
| show_sec | output | 8 | BCD seconds of the selected view |
| alm_hr | output | 8 | BCD alarm hours |
| alm_min | output | 8 | BCD alarm minutes |
| alm_sec | output | 8 | BCD alarm seconds |
| blink_hr | output | 1 | Hours field under adjustment |
| blink_min | output | 1 | Minutes field under adjustment |
| blink_sec | output | 1 | Seconds field under adjustment |
| view_alm | output | 1 | High while an alarm view or setting step is active |
| alarm_hit | output | 1 | Running time equals alarm time |

## Verification
The bench drives hours through the 23-to-00 wrap inside hour adjust and minutes through the 59-to-00 wrap inside minute adjust while the seconds also wrap. A design that lets carries ripple would show hours moving to 00 or minutes jumping by two. It holds the seconds-clear step for several ticks, where a leaky design would keep counting minutes. It presses keys in states where they must be ignored, and presses view and set together; a wrong sequencer would leave the clock view or start an adjust. It also runs the clock for an hour into a set alarm time, which catches a comparison that is wrong or always on, and a missing minute-to-hour carry.

// File: rtl/clock_alarm_ctrl.sv
module clock_alarm_ctrl #(
  parameter int DIV_BITS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_set,
  input  logic       key_step,
  input  logic       key_view,
  output logic [7:0] show_hr,
  output logic [7:0] show_min,
  output logic [7:0] show_sec,
  output logic [7:0] alm_hr,
  output logic [7:0] alm_min,
  output logic [7:0] alm_sec,
  output logic       blink_hr,
  output logic       blink_min,
  output logic       blink_sec,
  output logic       view_alm,
  output logic       alarm_hit
);

  typedef enum logic [2:0] {
    RUN, ADJ_H, ADJ_M, ZERO_S, ALM, SET_H, SET_M, SET_S
  } mode_t;

  localparam logic [7:0] TOP60 = 8'h59;
  localparam logic [7:0] TOP24 = 8'h23;

  mode_t mode;
  logic [DIV_BITS-1:0] div;
  logic [7:0] tod_hr, tod_min, tod_sec;
  logic tick, sec_wrap, min_wrap;

  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top);
    if (v == top) return 8'h00;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign tick     = &div;
  assign sec_wrap = tod_sec == TOP60;
  assign min_wrap = tod_min == TOP60;

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else     div <= div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= RUN;
    end else begin
      case (mode)
        RUN:     if (key_view) mode <= ALM;
                 else if (key_set) mode <= ADJ_H;
        ADJ_H:   if (key_step) mode <= ADJ_M;
        ADJ_M:   if (key_step) mode <= ZERO_S;
        ZERO_S:  if (key_step) mode <= RUN;
        ALM:     if (key_view) mode <= RUN;
                 else if (key_set) mode <= SET_H;
        SET_H:   if (key_step) mode <= SET_M;
        SET_M:   if (key_step) mode <= SET_S;
        default: if (key_step) mode <= ALM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_sec <= 8'h00;
      tod_min <= 8'h00;
      tod_hr  <= 8'h00;
    end else if (mode == ZERO_S) begin
      tod_sec <= 8'h00;
    end else if (tick) begin
      tod_sec <= bcd_next(tod_sec, TOP60);
      if (mode == ADJ_M || (mode != ADJ_H && sec_wrap) || (mode == ADJ_H && sec_wrap))
        if (mode == ADJ_M || sec_wrap) tod_min <= (mode == ADJ_M || sec_wrap) ? bcd_next(tod_min, TOP60) : tod_min;
      if (mode == ADJ_H)
        tod_hr <= bcd_next(tod_hr, TOP24);
      else if (mode != ADJ_M && sec_wrap && min_wrap)
        tod_hr <= bcd_next(tod_hr, TOP24);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_hr  <= 8'h00;
      alm_min <= 8'h00;
      alm_sec <= 8'h00;
    end else if (tick) begin
      if (mode == SET_H) alm_hr  <= bcd_next(alm_hr, TOP24);
      if (mode == SET_M) alm_min <= bcd_next(alm_min, TOP60);
      if (mode == SET_S) alm_sec <= bcd_next(alm_sec, TOP60);
    end
  end

  assign view_alm  = mode[2];
  assign blink_hr  = mode == ADJ_H  || mode == SET_H;
  assign blink_min = mode == ADJ_M  || mode == SET_M;
  assign blink_sec = mode == ZERO_S || mode == SET_S;

  assign show_hr  = view_alm ? alm_hr  : tod_hr;
  assign show_min = view_alm ? alm_min : tod_min;
  assign show_sec = view_alm ? alm_sec : tod_sec;

  assign alarm_hit = !(view_alm && mode != ALM) &&
                     tod_hr == alm_hr && tod_min == alm_min && tod_sec == alm_sec;

endmodule

// File: rtl/clock_alarm_ctrl_chk.sv
module clock_alarm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic [7:0] tod_hr,
  input logic [7:0] tod_min,
  input logic [7:0] tod_sec,
  input logic       view_alm,
  input logic       blink_hr,
  input logic       blink_min,
  input logic       blink_sec,
  input logic       alarm_hit
);

  assert_legal_bcd_R1: assert property (@(posedge clk) disable iff (rst)
    tod_hr <= 8'h23 && tod_hr[3:0] <= 4'd9 &&
    tod_min <= 8'h59 && tod_min[3:0] <= 4'd9 &&
    tod_sec <= 8'h59 && tod_sec[3:0] <= 4'd9);

  assert_seconds_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3) |=> tod_sec == 8'h00);

  assert_view_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd0 && mode != 3'd4) |=> view_alm == $past(view_alm));

  assert_no_hour_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2) |=> $stable(tod_hr));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (mode == 3'd0 && tod_hr == 8'h00 && tod_min == 8'h00 && tod_sec == 8'h00));

  assert_hit_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (view_alm && (blink_hr || blink_min || blink_sec)) |-> !alarm_hit);

endmodule

bind clock_alarm_ctrl clock_alarm_ctrl_chk chk (
  .clk(clk), .rst(rst), .mode(mode),
  .tod_hr(tod_hr), .tod_min(tod_min), .tod_sec(tod_sec),
  .view_alm(view_alm), .blink_hr(blink_hr), .blink_min(blink_min),
  .blink_sec(blink_sec), .alarm_hit(alarm_hit)
);

// File: tb/clock_alarm_ctrl_test.sv
module clock_alarm_ctrl_test;
  localparam int DIVB = 3;
  localparam int PER  = 1 << DIVB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_set = 1'b0, key_step = 1'b0, key_view = 1'b0;
  logic [7:0] show_hr, show_min, show_sec, alm_hr, alm_min, alm_sec;
  logic blink_hr, blink_min, blink_sec, view_alm, alarm_hit;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clock_alarm_ctrl #(.DIV_BITS(DIVB)) uut (
    .clk(clk), .rst(rst), .key_set(key_set), .key_step(key_step), .key_view(key_view),
    .show_hr(show_hr), .show_min(show_min), .show_sec(show_sec),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
    .blink_hr(blink_hr), .blink_min(blink_min), .blink_sec(blink_sec),
    .view_alm(view_alm), .alarm_hit(alarm_hit)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input logic [23:0] exp);
    chk(req, {show_hr, show_min, show_sec}, exp);
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk(req, {20'd0, view_alm, blink_hr, blink_min, blink_sec}, {20'd0, exp});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic secs(input int n);
    repeat (n * PER) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic press(input bit s, input bit k, input bit v);
    key_set = s; key_step = k; key_view = v;
    @(posedge clk);
    @(negedge clk);
    key_set = 1'b0; key_step = 1'b0; key_view = 1'b0;
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset_and_rate();
    do_reset();
    chk_time("R10 time cleared", 24'h000000);
    chk({"R10 alarm cleared"}, {alm_hr, alm_min, alm_sec}, 24'h000000);
    chk_flags("R10 clock display", 4'b0000);
    chk("R11 match at 00:00:00", {23'd0, alarm_hit}, 24'd1);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    chk_time("R2 no advance before tick", 24'h000000);
    @(posedge clk);
    @(negedge clk);
    chk_time("R2 advance on tick", 24'h000001);
    chk("R11 no match after advance", {23'd0, alarm_hit}, 24'd0);
    secs(58);
    chk_time("R1 seconds to 59", 24'h000059);
    secs(1);
    chk_time("R1 seconds wrap carries minute", 24'h000100);
  endtask

  task automatic test_clock_adjust();
    do_reset();
    press(1, 0, 0);
    chk_flags("R3 hour adjust flags", 4'b0100);
    chk_time("R4 hour adjust first tick, R9 seconds run", 24'h010001);
    secs(22);
    chk_time("R4 hours reach 23", 24'h230023);
    press(1, 0, 0);
    chk_flags("R3 set ignored in adjust", 4'b0100);
    chk_time("R4 hour wrap in adjust, R8 no carry", 24'h000024);
    secs(23);
    chk_time("R4 hours back to 23", 24'h230047);
    press(0, 1, 0);
    chk_flags("R3 minute adjust flags", 4'b0010);
    chk_time("R4 minute adjust first tick", 24'h230148);
    secs(57);
    chk_time("R8 seconds wrap leaves minutes, R9", 24'h235845);
    secs(1);
    chk_time("R4 minutes reach 59", 24'h235946);
    secs(1);
    chk_time("R8 minute wrap leaves hours", 24'h230047);
    secs(59);
    chk_time("R4 minutes back to 59", 24'h235946);
    press(0, 1, 0);
    chk_flags("R3 seconds-clear flags", 4'b0001);
    chk_time("R5 seconds cleared", 24'h235900);
    secs(3);
    chk_time("R5 fields held in seconds-clear", 24'h235900);
    press(0, 1, 0);
    chk_flags("R3 back to display", 4'b0000);
    chk_time("R3 counting resumes", 24'h235901);
    secs(58);
    chk_time("R1 at 23:59:59", 24'h235959);
    secs(1);
    chk_time("R1 full day wrap", 24'h000000);
  endtask

  task automatic test_alarm_set();
    do_reset();
    press(0, 0, 1);
    chk_flags("R7 view to alarm", 4'b1000);
    chk_time("R6 alarm shown", 24'h000000);
    press(1, 0, 0);
    chk_flags("R6 alarm hour flags", 4'b1100);
    chk_time("R6 alarm hour first tick", 24'h010000);
    secs(6);
    press(0, 1, 0);
    chk_flags("R6 alarm minute flags", 4'b1010);
    secs(29);
    press(0, 1, 0);
    chk_flags("R6 alarm second flags", 4'b1001);
    secs(4);
    press(0, 1, 0);
    chk_flags("R6 back to alarm display", 4'b1000);
    chk_time("R6 alarm shown after setting", 24'h073005);
    chk("R6 alarm outputs", {alm_hr, alm_min, alm_sec}, 24'h073005);
    press(0, 0, 1);
    chk_flags("R7 view back to clock", 4'b0000);
    chk_time("R6 clock unaffected", 24'h000045);
  endtask

  task automatic test_key_guards();
    do_reset();
    press(0, 1, 0);
    chk_flags("R3 step ignored in display", 4'b0000);
    press(1, 0, 1);
    chk_flags("R7 view wins over set", 4'b1000);
    chk_time("R7 alarm view shown", 24'h000000);
    press(0, 0, 1);
    chk_time("R7 clock view restored", 24'h000003);
    press(1, 0, 0);
    press(0, 0, 1);
    chk_flags("R7 view ignored in adjust", 4'b0100);
    press(0, 1, 0);
    press(0, 1, 0);
    press(0, 1, 0);
    chk_flags("R3 sequence closes", 4'b0000);
  endtask

  task automatic test_alarm_match();
    do_reset();
    press(0, 0, 1);
    press(1, 0, 0);
    press(0, 1, 0);
    press(0, 1, 0);
    press(0, 1, 0);
    press(0, 0, 1);
    chk("R6 alarm 01:01:01", {alm_hr, alm_min, alm_sec}, 24'h010101);
    secs(3654);
    chk_time("R1 hour carry in running", 24'h010100);
    chk("R11 no match one second early", {23'd0, alarm_hit}, 24'd0);
    secs(1);
    chk("R11 match at alarm time", {23'd0, alarm_hit}, 24'd1);
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    chk("R11 match held through second", {23'd0, alarm_hit}, 24'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R11 match drops", {23'd0, alarm_hit}, 24'd0);
  endtask

  initial begin
    @(negedge clk);
    test_reset_and_rate();
    test_clock_adjust();
    test_alarm_set();
    test_key_guards();
    test_alarm_match();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule